// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital front end of a 12-bit voltage-output converter. A host sends a code word over three wires: serial data, a serial clock and an active-low select. The word is collected in a shift register. Separately, an active-low load strobe copies the shift register into a holding register, which drives the converter. Because the two registers are separate, a new word can be shifted in while the converter keeps its present code. An active-low clear forces the holding register to zero scale.

All five pins are asynchronous to the system clock. Each pin passes through a synchronizer, and the serial clock's rising edges are detected in the system-clock domain. The system clock must run at least four times faster than the fastest serial clock. The block outputs the holding-register code and a derived output level in tenths of a millivolt. One code step is 0.5 mV, so the level equals the code times five.

Top module: `ser_dac_front`

## Requirements
- R1: The serial word is 12 bits, most significant bit first. After 12 bits and a load, `dac_code[11]` holds the first bit received and `dac_code[0]` holds the last.
- R2: A bit is shifted only on a rising edge of `sclk_pin`. A falling edge shifts nothing.
- R3: While `sel_n_pin` is high (1), edges on `sclk_pin` leave the shift register unchanged.
- R4: `sel_n_pin` has no effect on loading. A load while deselected still transfers the shift register.
- R5: While `load_n_pin` is low (0) and `clear_n_pin` is high, `dac_code` follows the shift register. While `load_n_pin` is high, `dac_code` holds its value.
- R6: `clear_n_pin` low forces `dac_code` to 0. The code stays 0 after clear is released, until the next load.
- R7: When clear and load are both low, clear wins and `dac_code` is 0.
- R8: After reset, `dac_code` is 0 and `out_level` is 0.
- R9: If more than 12 bits are shifted before a load, only the last 12 bits received are kept.
- R10: `out_level` equals `dac_code` times 5, in units of 0.1 mV. Code FFFh gives 20475, and code 001h gives 5.
- R11: A change on `load_n_pin` or `clear_n_pin` reaches `dac_code` on the third rising edge of `clk` after the pin change. Two of these edges are synchronizer stages and one is the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | Serial clock; data is shifted on its rising edge |
| sdata_pin | input | 1 | Serial data, most significant bit first |
| sel_n_pin | input | 1 | Active-low select; gates shifting only |
| load_n_pin | input | 1 | Active-low load strobe (level-sensitive) |
| clear_n_pin | input | 1 | Active-low clear of the holding register |
| dac_code | output | CODE_W (12) | Holding-register code driving the converter |
| out_level | output | LVL_W (15) | Output level in 0.1 mV units (code x 5) |

## Verification
A corrupt shift register stays hidden until the next load. Loading is therefore exercised both as short pulses and as a held-low strobe. A held-low strobe makes the shift register visible on `dac_code` three clock edges after every shifted bit. A wrong synchronizer depth or a mis-timed edge detector shows as a one-cycle shift of the update edge. The cycle-accurate reference catches this on the first affected clock. A bad clear path or a wrong load priority shows in `dac_code` within three edges of the pin change. Any error in the scaling shows in `out_level` in the same cycle as the code.

// File: rtl/ser_dac_pkg.sv
package ser_dac_pkg;

   // Synchronized pin bundle, in a fixed order used by the synchronizer bank.
   typedef struct packed {
      logic sclk;
      logic data;
      logic sel_n;
      logic load_n;
      logic clear_n;
   } pin_bus_t;

   localparam int PIN_COUNT = $bits(pin_bus_t);

   // Idle levels: clock low, data low, strobes and select inactive (high).
   localparam pin_bus_t PIN_IDLE = '{sclk: 1'b0, data: 1'b0, sel_n: 1'b1,
                                     load_n: 1'b1, clear_n: 1'b1};

   function automatic int level_width(input int code_w, input int step);
      return $clog2(((1 << code_w) - 1) * step + 1);
   endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdac_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sdac_sync: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              data_s,
   input  logic              sel_n_s,
   output logic              sclk_rise,
   output logic [CODE_W-1:0] shift_q
);
   if (CODE_W < 2) begin : g_bad_w
      $error("sdac_shifter: CODE_W must be at least 2");
   end

   logic sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign sclk_rise = sclk_s & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shift_q <= '0;
      else if (sclk_rise && !sel_n_s)
         shift_q <= {shift_q[CODE_W-2:0], data_s};
   end
endmodule

// File: rtl/sdac_holding.sv
module sdac_holding #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n_s,
   input  logic              clear_n_s,
   input  logic [CODE_W-1:0] shift_q,
   output logic [CODE_W-1:0] code_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         code_q <= '0;
      else if (!clear_n_s) code_q <= '0;
      else if (!load_n_s)  code_q <= shift_q;
   end
endmodule

// File: rtl/sdac_scale.sv
module sdac_scale #(
   parameter int CODE_W    = 12,
   parameter int STEP      = 5,
   parameter int LVL_W     = 15,
   parameter bit LEVEL_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic [LVL_W-1:0]  level
);
   if (STEP < 1) begin : g_bad_step
      $error("sdac_scale: STEP must be positive");
   end

   logic [LVL_W-1:0] product;
   assign product = LVL_W'(code) * LVL_W'(STEP);

   if (LEVEL_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level <= '0;
         else        level <= product;
      end
   end else begin : g_comb
      assign level = product;
   end
endmodule

// File: rtl/ser_dac_front.sv
module ser_dac_front
   import ser_dac_pkg::*;
#(
   parameter int CODE_W      = 12,
   parameter int STEP        = 5,
   parameter int SYNC_STAGES = 2,
   parameter int LVL_W       = ser_dac_pkg::level_width(CODE_W, STEP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_pin,
   input  logic              sdata_pin,
   input  logic              sel_n_pin,
   input  logic              load_n_pin,
   input  logic              clear_n_pin,
   output logic [CODE_W-1:0] dac_code,
   output logic [LVL_W-1:0]  out_level
);
   if (LVL_W < level_width(CODE_W, STEP)) begin : g_bad_lvl
      $error("ser_dac_front: LVL_W too narrow for full-scale level");
   end

   pin_bus_t pins_raw, pins_s;
   logic     sclk_s, data_s, sel_n_s, load_n_s, clear_n_s;
   logic     sclk_rise;
   logic [CODE_W-1:0] shift_q;

   assign pins_raw = '{sclk: sclk_pin, data: sdata_pin, sel_n: sel_n_pin,
                       load_n: load_n_pin, clear_n: clear_n_pin};

   sdac_sync #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pins_raw),
      .q_sync (pins_s)
   );

   assign sclk_s    = pins_s.sclk;
   assign data_s    = pins_s.data;
   assign sel_n_s   = pins_s.sel_n;
   assign load_n_s  = pins_s.load_n;
   assign clear_n_s = pins_s.clear_n;

   sdac_shifter #(.CODE_W(CODE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .data_s   (data_s),
      .sel_n_s  (sel_n_s),
      .sclk_rise(sclk_rise),
      .shift_q  (shift_q)
   );

   sdac_holding #(.CODE_W(CODE_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_n_s (load_n_s),
      .clear_n_s(clear_n_s),
      .shift_q  (shift_q),
      .code_q   (dac_code)
   );

   sdac_scale #(
      .CODE_W   (CODE_W),
      .STEP     (STEP),
      .LVL_W    (LVL_W),
      .LEVEL_REG(1'b0)
   ) u_scale (
      .clk  (clk),
      .rst_n(rst_n),
      .code (dac_code),
      .level(out_level)
   );
endmodule

// File: rtl/ser_dac_front_chk.sv
module ser_dac_front_chk #(
   parameter int CODE_W = 12,
   parameter int STEP   = 5,
   parameter int LVL_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n_s,
   input logic              load_n_s,
   input logic              clear_n_s,
   input logic              sclk_rise,
   input logic [CODE_W-1:0] shift_q,
   input logic [CODE_W-1:0] dac_code,
   input logic [LVL_W-1:0]  out_level
);
   assert_no_shift_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(shift_q));

   assert_deselect_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_s |=> $stable(shift_q));

   assert_hold_while_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n_s && clear_n_s) |=> $stable(dac_code));

   assert_load_transfers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n_s && clear_n_s) |=> (dac_code == $past(shift_q)));

   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n_s |=> (dac_code == '0));

   assert_clear_beats_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_n_s && !load_n_s) |=> (dac_code == '0));

   assert_level_scale_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_level % LVL_W'(STEP)) == '0) && ((out_level / LVL_W'(STEP)) == LVL_W'(dac_code)));
endmodule

bind ser_dac_front ser_dac_front_chk #(
   .CODE_W(CODE_W),
   .STEP  (STEP),
   .LVL_W (LVL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_n_s  (sel_n_s),
   .load_n_s (load_n_s),
   .clear_n_s(clear_n_s),
   .sclk_rise(sclk_rise),
   .shift_q  (shift_q),
   .dac_code (dac_code),
   .out_level(out_level)
);

// File: tb/ser_dac_front_test.sv
module ser_dac_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_pin = 1'b0, sdata_pin = 1'b0, sel_n_pin = 1'b1;
   logic load_n_pin = 1'b1, clear_n_pin = 1'b1;
   logic [11:0] dac_code;
   logic [14:0] out_level;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_dac_front uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_pin   (sclk_pin),
      .sdata_pin  (sdata_pin),
      .sel_n_pin  (sel_n_pin),
      .load_n_pin (load_n_pin),
      .clear_n_pin(clear_n_pin),
      .dac_code   (dac_code),
      .out_level  (out_level)
   );

   // Behavioural reference: pins seen two clocks late, then the register rules.
   bit [4:0]  h1, h2;        // {sclk, data, sel_n, load_n, clear_n}
   bit        m_prev;
   int        m_shift, m_code;

   always @(posedge clk) begin
      if (!rst_n) begin
         h1 = 5'b00111; h2 = 5'b00111; m_prev = 0; m_shift = 0; m_code = 0;
      end else begin
         int old_shift;
         old_shift = m_shift;
         if (h2[4] && !m_prev && !h2[2])
            m_shift = ((m_shift * 2) + h2[3]) % 4096;
         if (!h2[0])      m_code = 0;
         else if (!h2[1]) m_code = old_shift;
         m_prev = h2[4];
         h2 = h1;
         h1 = {sclk_pin, sdata_pin, sel_n_pin, load_n_pin, clear_n_pin};
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_checks++;
         if (int'(dac_code) != m_code || int'(out_level) != m_code * 5) begin
            n_errors++;
            $display("FAIL R11 cycle model: code=%h level=%0d expected code=%h level=%0d",
                     dac_code, out_level, m_code, m_code * 5);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input int word, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdata_pin = word[i];
         sclk_pin  = 1'b0;
         wait_clk(3);
         sclk_pin  = 1'b1;
         wait_clk(3);
      end
      sclk_pin = 1'b0;
      wait_clk(3);
   endtask

   task automatic pulse_load();
      load_n_pin = 1'b0;
      wait_clk(4);
      load_n_pin = 1'b1;
      wait_clk(4);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(5);
      chk("R8 reset code", dac_code, 0);
      chk("R8 reset level", out_level, 0);

      // R1: MSB first, R5: no transfer without load
      sel_n_pin = 1'b0;
      shift_bits(12'hA5C, 12);
      chk("R5 hold before load", dac_code, 0);
      pulse_load();
      chk("R1 msb first", dac_code, 12'hA5C);
      chk("R10 level A5C", out_level, 13260);

      // R3: clocks while deselected shift nothing
      sel_n_pin = 1'b1;
      wait_clk(3);
      shift_bits(12'h0F0, 12);
      pulse_load();
      chk("R3 deselected no shift", dac_code, 12'hA5C);

      // R4: load while deselected still transfers
      sel_n_pin = 1'b0;
      wait_clk(3);
      shift_bits(12'h3C1, 12);
      sel_n_pin = 1'b1;
      wait_clk(3);
      pulse_load();
      chk("R4 load while deselected", dac_code, 12'h3C1);

      // R9: extra bits keep the last twelve
      sel_n_pin = 1'b0;
      shift_bits(16'hF123, 16);
      pulse_load();
      chk("R9 last twelve bits", dac_code, 12'h123);

      // R6: clear forces zero and stays zero afterwards
      clear_n_pin = 1'b0;
      wait_clk(4);
      chk("R6 clear zero", dac_code, 0);
      clear_n_pin = 1'b1;
      wait_clk(6);
      chk("R6 stays zero after clear", dac_code, 0);

      // R7: clear wins over load; R5 transparent once clear releases
      shift_bits(12'hFFF, 12);
      clear_n_pin = 1'b0;
      load_n_pin  = 1'b0;
      wait_clk(5);
      chk("R7 clear beats load", dac_code, 0);
      clear_n_pin = 1'b1;
      wait_clk(4);
      chk("R5 load low follows shift", dac_code, 12'hFFF);
      chk("R10 level full scale", out_level, 20475);
      shift_bits(12'hFF0, 4);
      chk("R5 transparent tracks shifting", dac_code, 12'hFF0);
      load_n_pin = 1'b1;
      wait_clk(4);
      shift_bits(12'h001, 12);
      chk("R5 holds when load high", dac_code, 12'hFF0);

      // R11: load reaches the code on the third clock edge
      load_n_pin = 1'b0;
      wait_clk(2);
      chk("R11 not yet after two edges", dac_code, 12'hFF0);
      wait_clk(1);
      chk("R11 updated on third edge", dac_code, 12'h001);
      chk("R10 level one step", out_level, 5);
      load_n_pin = 1'b1;
      wait_clk(4);

      // R2: only the rising edge shifts
      sdata_pin = 1'b1;
      sclk_pin  = 1'b1;
      wait_clk(4);
      sdata_pin = 1'b0;
      sclk_pin  = 1'b0;
      wait_clk(4);
      pulse_load();
      chk("R2 rising edge only", dac_code, 12'h003);

      wait_clk(4);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule